// File: doc/BRIEF.md
# Single-Bit Rotate and Shift Unit with Flag Update

This block performs one-position rotates and a logical right shift on an 8-bit operand, as an accumulator-style processor core does. It also produces the updated condition flags and the number of clock cycles the operation costs the core. An operation arrives as a single transfer on a valid/ready input stream. The transfer carries the operand, the current flag nibble, a 3-bit operation code and a form select. The form select picks the short accumulator form of a rotate or the general register form. One cycle after the transfer is accepted, the result, the packed flag byte, an illegal-operation marker and the cycle cost are presented on a valid/ready output stream.

Both streams obey the usual back-pressure rules. A transfer happens on a rising clock edge where valid and ready are both high. While the output holds a result that the consumer has not taken, every output field stays unchanged. The input accepts a new operation only if the output register is empty, or if the output register is being emptied in that same cycle. With `out_ready` held high, the unit accepts one operation every cycle.

Top module: `rsf_unit`

## Requirements
- R1: Operation code 0 (rotate left circular) gives the result {x[6:0], x[7]} and sets C to x[7].
- R2: Operation code 1 (rotate left through carry) gives the result {x[6:0], Cin} and sets C to x[7]. Cin is bit 0 of `in_flags`.
- R3: Operation code 2 (logical shift right) gives the result {0, x[7:1]} and sets C to x[0]. Z is 1 exactly when that result is zero, and `in_acc_form` has no effect on this operation.
- R4: Operation code 3 (rotate right circular) gives the result {x[0], x[7:1]} and sets C to x[0].
- R5: For the rotates (codes 0, 1, 3), Z is forced to 0 when `in_acc_form` is 1, whatever the result. When `in_acc_form` is 0, Z is 1 exactly when the result is zero.
- R6: `out_flags` packs Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3..0 are always 0. N and H are 0 after every legal operation.
- R7: Operation codes 4 to 7 are illegal. An illegal operation returns the operand unchanged, sets `out_flags` to {`in_flags`, 4'b0000} and raises `out_illegal` together with the result.
- R8: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high right after that edge, which is one cycle later.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay stable. `in_ready` is high exactly when the output register is empty or is being drained.
- R10: `out_cycles` is 4 for an accumulator-form rotate and for an illegal operation. It is 8 for a register-form rotate and for the shift (codes 0 to 3 with `in_acc_form` 0, and code 2 in either form).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_operand | input | 8 | Operand x |
| in_flags | input | 4 | Current flags {Z,N,H,C}; C (bit 0) is the incoming carry |
| in_op | input | 3 | Operation code (0 RLC, 1 RL, 2 SRL, 3 RRC, 4..7 illegal) |
| in_acc_form | input | 1 | 1 selects the accumulator form of a rotate |
| out_valid | output | 1 | A result is held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Rotated or shifted value |
| out_flags | output | 8 | Packed flags: Z bit 7, N bit 6, H bit 5, C bit 4, bits 3..0 zero |
| out_illegal | output | 1 | Operation code was illegal |
| out_cycles | output | 4 | Clock-cycle cost of the operation |

## Verification
Every result is due one clock edge after its input transfer. It then stays on the outputs until the first edge at which `out_ready` is high. The bench therefore drives inputs on the falling edge and samples a quarter period later. When it sees an input handshake pending, it pushes the expected item into a queue. When it sees an output handshake pending, it pops the oldest item and compares it with the outputs. Any cycle in which the output is stalled is followed by a check that the held values did not change. One isolated transfer is also timed to confirm that `out_valid` rises after exactly one edge.

// File: rtl/rsf_pkg.sv
`timescale 1ns/1ps
package rsf_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RLC = 3'd0,
    OP_RL  = 3'd1,
    OP_SRL = 3'd2,
    OP_RRC = 3'd3
  } rsf_op_e;

  // positions inside the packed output flag byte
  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    return op <= OP_W'(OP_RRC);
  endfunction

  function automatic logic op_is_rotate(input logic [OP_W-1:0] op);
    return op_is_legal(op) && (op != OP_W'(OP_SRL));
  endfunction

endpackage

// File: rtl/rsf_shifter.sv
`timescale 1ns/1ps
module rsf_shifter
  import rsf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    case (op)
      OP_RLC: begin
        result    = {operand[MSB-1:0], operand[MSB]};
        carry_out = operand[MSB];
      end
      OP_RL: begin
        result    = {operand[MSB-1:0], carry_in};
        carry_out = operand[MSB];
      end
      OP_SRL: begin
        result    = {1'b0, operand[MSB:1]};
        carry_out = operand[0];
      end
      OP_RRC: begin
        result    = {operand[0], operand[MSB:1]};
        carry_out = operand[0];
      end
      default: begin
        result    = operand;
        carry_out = carry_in;
      end
    endcase
  end
endmodule

// File: rtl/rsf_flagger.sv
`timescale 1ns/1ps
module rsf_flagger
  import rsf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  input  logic [OP_W-1:0]   op,
  input  logic              acc_form,
  input  logic [3:0]        flags_in,
  output logic [7:0]        flags_out
);
  logic legal;
  logic force_z_low;
  logic z_val;

  assign legal       = op_is_legal(op);
  assign force_z_low = op_is_rotate(op) && acc_form;
  assign z_val       = force_z_low ? 1'b0 : (result == '0);

  always_comb begin
    flags_out = '0;
    if (legal) begin
      flags_out[FZ] = z_val;
      flags_out[FN] = 1'b0;
      flags_out[FH] = 1'b0;
      flags_out[FC] = carry_out;
    end else begin
      flags_out[7:4] = flags_in;
    end
  end
endmodule

// File: rtl/rsf_cost.sv
`timescale 1ns/1ps
module rsf_cost
  import rsf_pkg::*;
#(
  parameter int CYC_W      = 4,
  parameter int ACC_CYCLES = 4,
  parameter int REG_CYCLES = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic             acc_form,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [CYC_W-1:0] SHORT_C = CYC_W'(ACC_CYCLES);
  localparam logic [CYC_W-1:0] LONG_C  = CYC_W'(REG_CYCLES);

  always_comb begin
    if (!op_is_legal(op))
      cycles = SHORT_C;
    else if (op_is_rotate(op) && acc_form)
      cycles = SHORT_C;
    else
      cycles = LONG_C;
  end
endmodule

// File: rtl/rsf_unit.sv
`timescale 1ns/1ps
module rsf_unit
  import rsf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CYC_W      = 4,
  parameter int ACC_CYCLES = 4,
  parameter int REG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [3:0]        in_flags,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_acc_form,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [7:0]        out_flags,
  output logic              out_illegal,
  output logic [CYC_W-1:0]  out_cycles
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] nx_result;
  logic              nx_carry;
  logic [7:0]        nx_flags;
  logic [CYC_W-1:0]  nx_cycles;
  logic              accept;
  logic              legal;

  rsf_shifter #(.DATA_W(DATA_W)) u_shift (
    .operand   (in_operand),
    .carry_in  (in_flags[0]),
    .op        (in_op),
    .result    (nx_result),
    .carry_out (nx_carry)
  );

  rsf_flagger #(.DATA_W(DATA_W)) u_flag (
    .result    (nx_result),
    .carry_out (nx_carry),
    .op        (in_op),
    .acc_form  (in_acc_form),
    .flags_in  (in_flags),
    .flags_out (nx_flags)
  );

  rsf_cost #(
    .CYC_W      (CYC_W),
    .ACC_CYCLES (ACC_CYCLES),
    .REG_CYCLES (REG_CYCLES)
  ) u_cost (
    .op       (in_op),
    .acc_form (in_acc_form),
    .cycles   (nx_cycles)
  );

  assign legal    = op_is_legal(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_flags   <= '0;
      out_illegal <= 1'b0;
      out_cycles  <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nx_result;
      out_flags   <= nx_flags;
      out_illegal <= !legal;
      out_cycles  <= nx_cycles;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_RLC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_op == OP_RLC) |=> (out_result[0] == $past(in_operand[MSB]) && out_flags[FC] == $past(in_operand[MSB]))); // R1
  AST_RL_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_op == OP_RL) |=> (out_result[0] == $past(in_flags[0]) && out_flags[FC] == $past(in_operand[MSB]))); // R2
  AST_SRL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_op == OP_SRL) |=> (out_result[MSB] == 1'b0 && out_flags[FC] == $past(in_operand[0]))); // R3
  AST_RRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_op == OP_RRC) |=> (out_result[MSB] == $past(in_operand[0]) && out_flags[FC] == $past(in_operand[0]))); // R4
  AST_ACC_Z_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_acc_form && op_is_rotate(in_op)) |=> !out_flags[FZ]); // R5
  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3:0] == 4'h0)); // R6
  AST_NH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_flags[FN] == 1'b0 && out_flags[FH] == 1'b0)); // R6
  AST_ILLEGAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && !legal) |=> (out_illegal && out_result == $past(in_operand))); // R7
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept) |=> out_valid); // R8
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_cycles) && $stable(out_illegal))); // R9
  AST_SHORT_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && accept && in_acc_form && op_is_rotate(in_op)) |=> (out_cycles == CYC_W'(ACC_CYCLES))); // R10
endmodule

// File: tb/rsf_unit_test.sv
`timescale 1ns/1ps
module rsf_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_operand = '0;
  logic [3:0] in_flags = '0;
  logic [2:0] in_op = '0;
  logic       in_acc_form = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [7:0] out_flags;
  logic       out_illegal;
  logic [3:0] out_cycles;

  int checks = 0;
  int failures = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic [7:0] fl;
    logic       ill;
    logic [3:0] cyc;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  rsf_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_flags(in_flags),
    .in_op(in_op), .in_acc_form(in_acc_form),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags),
    .out_illegal(out_illegal), .out_cycles(out_cycles)
  );

  function automatic exp_t model(input logic [2:0] op, input logic acc,
                                 input logic [7:0] x, input logic [3:0] fl);
    exp_t e;
    logic c;
    logic z;
    e.ill = 1'b0;
    e.res = x;
    c = fl[0];
    case (op)
      3'd0: begin e.res = {x[6:0], x[7]}; c = x[7]; e.tag = "R1 R5 R6 R10"; end
      3'd1: begin e.res = {x[6:0], fl[0]}; c = x[7]; e.tag = "R2 R5 R6 R10"; end
      3'd2: begin e.res = {1'b0, x[7:1]}; c = x[0]; e.tag = "R3 R6 R10"; end
      3'd3: begin e.res = {x[0], x[7:1]}; c = x[0]; e.tag = "R4 R5 R6 R10"; end
      default: begin e.ill = 1'b1; e.tag = "R7 R10"; end
    endcase
    if (e.ill) begin
      e.fl  = {fl, 4'h0};
      e.cyc = 4'd4;
    end else begin
      z = (op != 3'd2 && acc) ? 1'b0 : (e.res == 8'h00);
      e.fl  = {z, 1'b0, 1'b0, c, 4'h0};
      e.cyc = (op != 3'd2 && acc) ? 4'd4 : 4'd8;
    end
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic acc,
                      input logic [7:0] x, input logic [3:0] fl);
    @(negedge clk);
    in_valid    = 1'b1;
    in_op       = op;
    in_acc_form = acc;
    in_operand  = x;
    in_flags    = fl;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    sb.push_back(model(op, acc, x, fl));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // output ready pattern: always high, or a stall pattern when enabled
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      out_ready = stall_mode ? ((k % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit         was_stalled = 1'b0;
    logic [7:0] h_res;
    logic [7:0] h_fl;
    logic [3:0] h_cyc;
    logic       h_ill;
    exp_t       e;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (was_stalled) begin
          checks++;
          if (!out_valid || out_result !== h_res || out_flags !== h_fl ||
              out_cycles !== h_cyc || out_illegal !== h_ill) begin
            failures++;
            $display("FAIL R9 stall hold: actual v=%0b res=%02h fl=%02h expected v=1 res=%02h fl=%02h",
                     out_valid, out_result, out_flags, h_res, h_fl);
          end
        end
        was_stalled = out_valid && !out_ready;
        h_res = out_result; h_fl = out_flags; h_cyc = out_cycles; h_ill = out_illegal;
        if (out_valid && out_ready) begin
          checks++;
          if (sb.size() == 0) begin
            failures++;
            $display("FAIL R8 unexpected output: actual res=%02h expected none", out_result);
          end else begin
            e = sb.pop_front();
            if (out_result !== e.res || out_flags !== e.fl ||
                out_illegal !== e.ill || out_cycles !== e.cyc) begin
              failures++;
              $display("FAIL %s: actual res=%02h fl=%02h ill=%0b cyc=%0d expected res=%02h fl=%02h ill=%0b cyc=%0d",
                       e.tag, out_result, out_flags, out_illegal, out_cycles,
                       e.res, e.fl, e.ill, e.cyc);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #3000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R8 R9 reset: actual out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // full sweep, free-flowing output
    for (int op = 0; op < 4; op++)
      for (int acc = 0; acc < 2; acc++)
        for (int cin = 0; cin < 2; cin++)
          for (int x = 0; x < 256; x++)
            send(3'(op), 1'(acc), 8'(x), {x[3], x[2], x[1], 1'(cin)});

    // illegal codes and a stalled output stream
    stall_mode = 1'b1;
    for (int op = 4; op < 8; op++)
      for (int x = 0; x < 16; x++)
        send(3'(op), 1'(x & 1), 8'(x * 17 + op), 4'(x));
    for (int x = 0; x < 64; x++)
      send(3'(x % 4), 1'(x / 32), 8'(x * 37), 4'(x));
    stall_mode = 1'b0;

    // single isolated transfer timing
    repeat (6) @(negedge clk);
    send(3'd3, 1'b1, 8'h01, 4'h0);
    @(negedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL R8 latency: actual out_valid=%0b expected 1", out_valid);
    end

    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R8 drain: actual pending=%0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule